// File: doc/BRIEF.md
# Interrupt and Reset Entry Controller

This block steers a CPU core into its service routines. It holds the two interrupt-enable flip-flops and the interrupt mode, and it decides whether a pending interrupt is taken. A maskable request is only taken when the primary enable flip-flop is set. A rising edge on the non-maskable input is always taken and wins over a maskable request that arrives in the same cycle. Reset clears the enables and the mode.

For a maskable interrupt the block runs the acknowledge bus cycle on its own. It drives the opcode-fetch strobe, then the I/O request strobe late in the cycle, captures the byte the device places on the data bus, and closes with a refresh phase. The mode then decides what happens next. Mode 0 hands the byte to the core as the next opcode. Mode 1 calls the fixed restart address. Mode 2 reads a 16-bit little-endian entry from a vector table, indexed by the page register and the device byte, and calls that entry.

A non-maskable interrupt saves the primary enable into the secondary one, clears the primary, pulses the fetch strobe, releases a halted core and calls its fixed address. All calls go to a push-and-jump engine through a request/acknowledge handshake. A return-from-NMI command from the core copies the saved enable back.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After synchronous reset both enable flags read 0, the mode reads 0, m1_n, iorq_n and rfsh_n are high, and call_req, vec_rd_req, op_inject and busy are low.
- R2: While idle, and with no interrupt taken in that cycle, ei_cmd sets both enables, di_cmd clears both, and im_wr loads im_sel into the mode.
- R3: A maskable request is taken in an idle cycle only when the primary enable is 1. Taking it clears both enables. With the primary enable at 0, a held int_req leaves all strobes high and busy low.
- R4: Cycles after the accepting edge are numbered from 1. m1_n is low in cycles 1 to 4 and iorq_n is low in cycle 4 only. bus_data is captured at the edge that ends cycle 4. rfsh_n is low in cycle 5 only, and all three strobes are high in cycle 6.
- R5: In mode 0, op_inject is high in cycle 7 for one cycle and op_byte carries the captured byte. No call is requested.
- R6: In mode 1, and also in mode 3, call_req rises in cycle 7 with call_addr 0x0038.
- R7: In mode 2, cycle 7 is idle on the bus. From cycle 8 the block reads the low byte at {page, byte} and then the high byte at {page, byte}+1, with a 16-bit wrap, each completed by vec_rd_ack. It then calls the address {high, low}.
- R8: A rising edge of nmi_in is taken at the next idle edge. In the next cycle halt_release is high and m1_n is low for that one cycle, the secondary enable takes the old primary value, and the primary enable is cleared. In the cycle after that, call_req is high with call_addr 0x0066. A level held high does not retrigger.
- R9: When a rising edge of nmi_in and an enabled int_req arrive together, the non-maskable sequence runs and no acknowledge cycle starts.
- R10: retn_cmd in an idle cycle copies the secondary enable into the primary enable.
- R11: call_req stays high with a stable call_addr until call_ack. At the edge that samples call_ack the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, taken on its rising edge |
| int_req | input | 1 | Maskable request, level |
| bus_data | input | 8 | Data bus, read during acknowledge |
| i_page | input | 8 | Vector table page register value |
| ei_cmd | input | 1 | Enable interrupts |
| di_cmd | input | 1 | Disable interrupts |
| retn_cmd | input | 1 | Restore primary enable from secondary |
| im_wr | input | 1 | Load interrupt mode |
| im_sel | input | 2 | Mode value to load |
| m1_n | output | 1 | Opcode-fetch strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| halt_release | output | 1 | Releases a halted core |
| vec_rd_req | output | 1 | Vector table read request |
| vec_rd_addr | output | 16 | Vector table read address |
| vec_rd_ack | input | 1 | Vector read completes with data |
| vec_rd_data | input | 8 | Vector read data |
| call_req | output | 1 | Call request to push-and-jump engine |
| call_addr | output | 16 | Call target |
| call_ack | input | 1 | Call accepted |
| op_inject | output | 1 | Mode 0 opcode valid |
| op_byte | output | 8 | Mode 0 opcode |
| iff1 | output | 1 | Primary interrupt enable |
| iff2 | output | 1 | Secondary interrupt enable |
| im_mode | output | 2 | Current interrupt mode |
| busy | output | 1 | Entry sequence in progress |

## Verification
The acknowledge sequence is driven from a table that covers every mode value with different page and device bytes. The same six-cycle strobe pattern must appear each time, and only the part after cycle 6 may differ, so a change in strobe timing shows up apart from a change in target. Two mode-2 entries sit on a page boundary and at the top of the address space, which separates a correct 16-bit carry from a byte-wide one. Directed cases cover a masked request, a non-maskable request taken with the enable set and with it clear, a request that collides with a maskable one, and a held non-maskable level. Together these tell apart the save, the restore, the priority and the edge detection.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_NMI, S_ACK, S_GAP, S_RDLO, S_RDHI, S_CALL
  } entry_state_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic take,
  output logic hit
);
  logic lvl_q, pend_q;
  logic rise;
  assign rise = lvl & ~lvl_q;
  assign hit  = rise | pend_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (take)      pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_enable_flags.sv
module irq_enable_flags #(
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_en,
  input  logic          ei_cmd,
  input  logic          di_cmd,
  input  logic          retn_cmd,
  input  logic          im_wr,
  input  logic [MW-1:0] im_sel,
  input  logic          take_nmi,
  input  logic          take_int,
  output logic          iff1,
  output logic          iff2,
  output logic [MW-1:0] im_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      im_mode <= '0;
    end else if (take_nmi) begin
      iff2 <= iff1;
      iff1 <= 1'b0;
    end else if (take_int) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (cmd_en) begin
      if (di_cmd) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (ei_cmd) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end else if (retn_cmd) begin
        iff1 <= iff2;
      end
      if (im_wr) im_mode <= im_sel;
    end
  end
endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int ACK_LEN = 6,
  parameter int IORQ_AT = 4,
  parameter int RFSH_AT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic m1_low,
  output logic iorq_low,
  output logic rfsh_low,
  output logic sample,
  output logic done
);
  localparam int CW = $clog2(ACK_LEN + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (start)                 cnt <= CW'(1);
    else if (cnt == CW'(ACK_LEN))   cnt <= '0;
    else if (cnt != '0)             cnt <= cnt + CW'(1);
  end
  assign m1_low   = (cnt != '0) && (cnt <= CW'(IORQ_AT));
  assign iorq_low = (cnt == CW'(IORQ_AT));
  assign rfsh_low = (cnt == CW'(RFSH_AT));
  assign sample   = iorq_low;
  assign done     = (cnt == CW'(ACK_LEN));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MW      = 2,
  parameter int ACK_LEN = 6,
  parameter int IORQ_AT = 4,
  parameter int RFSH_AT = 5,
  parameter int NMI_VEC = 16'h0066,
  parameter int RST_VEC = 16'h0038
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nmi_in,
  input  logic            int_req,
  input  logic [DW-1:0]   bus_data,
  input  logic [DW-1:0]   i_page,
  input  logic            ei_cmd,
  input  logic            di_cmd,
  input  logic            retn_cmd,
  input  logic            im_wr,
  input  logic [MW-1:0]   im_sel,
  output logic            m1_n,
  output logic            iorq_n,
  output logic            rfsh_n,
  output logic            halt_release,
  output logic            vec_rd_req,
  output logic [2*DW-1:0] vec_rd_addr,
  input  logic            vec_rd_ack,
  input  logic [DW-1:0]   vec_rd_data,
  output logic            call_req,
  output logic [2*DW-1:0] call_addr,
  input  logic            call_ack,
  output logic            op_inject,
  output logic [DW-1:0]   op_byte,
  output logic            iff1,
  output logic            iff2,
  output logic [MW-1:0]   im_mode,
  output logic            busy
);
  localparam int AW = 2 * DW;

  entry_state_t st;
  logic [DW-1:0] vbyte_q, page_q;
  logic [AW-1:0] tgt_q, tbl_base;
  logic          inj_q;
  logic          nmi_hit, take_nmi, take_int, cmd_en;
  logic          t_m1, t_iorq, t_rfsh, t_sample, t_done;

  assign take_nmi = (st == S_IDLE) && nmi_hit;
  assign take_int = (st == S_IDLE) && !nmi_hit && int_req && iff1;
  assign cmd_en   = (st == S_IDLE) && !take_nmi && !take_int;

  irq_nmi_edge u_edge (
    .clk(clk), .rst(rst), .lvl(nmi_in), .take(take_nmi), .hit(nmi_hit)
  );

  irq_enable_flags #(.MW(MW)) u_flags (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
    .retn_cmd(retn_cmd), .im_wr(im_wr), .im_sel(im_sel),
    .take_nmi(take_nmi), .take_int(take_int),
    .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
  );

  irq_ack_timer #(.ACK_LEN(ACK_LEN), .IORQ_AT(IORQ_AT), .RFSH_AT(RFSH_AT)) u_timer (
    .clk(clk), .rst(rst), .start(take_int),
    .m1_low(t_m1), .iorq_low(t_iorq), .rfsh_low(t_rfsh),
    .sample(t_sample), .done(t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      vbyte_q <= '0;
      page_q  <= '0;
      tgt_q   <= '0;
      inj_q   <= 1'b0;
    end else begin
      inj_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (take_nmi)      st <= S_NMI;
          else if (take_int) st <= S_ACK;
        end
        S_NMI: begin
          tgt_q <= AW'(NMI_VEC);
          st    <= S_CALL;
        end
        S_ACK: begin
          if (t_sample) begin
            vbyte_q <= bus_data;
            page_q  <= i_page;
          end
          if (t_done) begin
            if (im_mode == MW'(0)) begin
              inj_q <= 1'b1;
              st    <= S_IDLE;
            end else if (im_mode == MW'(2)) begin
              st <= S_GAP;
            end else begin
              tgt_q <= AW'(RST_VEC);
              st    <= S_CALL;
            end
          end
        end
        S_GAP: st <= S_RDLO;
        S_RDLO: if (vec_rd_ack) begin
          tgt_q[DW-1:0] <= vec_rd_data;
          st            <= S_RDHI;
        end
        S_RDHI: if (vec_rd_ack) begin
          tgt_q[AW-1:DW] <= vec_rd_data;
          st             <= S_CALL;
        end
        S_CALL: if (call_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tbl_base     = {page_q, vbyte_q};
  assign vec_rd_addr  = tbl_base + AW'(st == S_RDHI);
  assign vec_rd_req   = (st == S_RDLO) || (st == S_RDHI);
  assign m1_n         = !(t_m1 || (st == S_NMI));
  assign iorq_n       = !t_iorq;
  assign rfsh_n       = !t_rfsh;
  assign halt_release = (st == S_NMI);
  assign call_req     = (st == S_CALL);
  assign call_addr    = tgt_q;
  assign op_inject    = inj_q;
  assign op_byte      = vbyte_q;
  assign busy         = (st != S_IDLE);
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int AW = 16,
  parameter logic [15:0] NMI_ADDR = 16'h0066
) (
  input logic          clk,
  input logic          rst,
  input logic          m1_n,
  input logic          iorq_n,
  input logic          rfsh_n,
  input logic          halt_release,
  input logic          call_req,
  input logic          call_ack,
  input logic [AW-1:0] call_addr,
  input logic          op_inject,
  input logic          iff1,
  input logic          iff2
);
  a_r4_iorq_inside_m1: assert property (@(posedge clk) disable iff (rst)
    !iorq_n |-> !m1_n);
  a_r4_rfsh_after_iorq: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> $past(!iorq_n) && m1_n);
  a_r3_flags_clear_in_ack: assert property (@(posedge clk) disable iff (rst)
    !iorq_n |-> !iff1 && !iff2);
  a_r8_nmi_target: assert property (@(posedge clk) disable iff (rst)
    halt_release |=> call_req && call_addr == AW'(NMI_ADDR));
  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    call_req && !call_ack |=> call_req && $stable(call_addr));
  a_r5_inject_after_refresh: assert property (@(posedge clk) disable iff (rst)
    op_inject |-> $past(!rfsh_n, 2) && !call_req);
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.AW(2*DW)) u_chk (
  .clk(clk), .rst(rst), .m1_n(m1_n), .iorq_n(iorq_n), .rfsh_n(rfsh_n),
  .halt_release(halt_release), .call_req(call_req), .call_ack(call_ack),
  .call_addr(call_addr), .op_inject(op_inject), .iff1(iff1), .iff2(iff2)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_in = 0, int_req = 0, ei_cmd = 0, di_cmd = 0, retn_cmd = 0, im_wr = 0;
  logic [7:0] bus_data = 0, i_page = 0, vec_rd_data = 0;
  logic [1:0] im_sel = 0;
  logic vec_rd_ack = 0, call_ack = 0;
  logic m1_n, iorq_n, rfsh_n, halt_release, vec_rd_req, call_req, op_inject;
  logic iff1, iff2, busy;
  logic [15:0] vec_rd_addr, call_addr;
  logic [7:0] op_byte;
  logic [1:0] im_mode;
  int checks = 0, errors = 0, cyc = 0;
  bit  done_flag = 0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .int_req(int_req), .bus_data(bus_data),
    .i_page(i_page), .ei_cmd(ei_cmd), .di_cmd(di_cmd), .retn_cmd(retn_cmd),
    .im_wr(im_wr), .im_sel(im_sel), .m1_n(m1_n), .iorq_n(iorq_n), .rfsh_n(rfsh_n),
    .halt_release(halt_release), .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
    .vec_rd_ack(vec_rd_ack), .vec_rd_data(vec_rd_data), .call_req(call_req),
    .call_addr(call_addr), .call_ack(call_ack), .op_inject(op_inject),
    .op_byte(op_byte), .iff1(iff1), .iff2(iff2), .im_mode(im_mode), .busy(busy)
  );

  // mode[17:16], page[15:8], device byte[7:0]
  localparam logic [17:0] VECS [6] = '{
    {2'd0, 8'h00, 8'hC7}, {2'd1, 8'h40, 8'h12}, {2'd3, 8'h00, 8'h34},
    {2'd2, 8'h80, 8'h10}, {2'd2, 8'h12, 8'hFF}, {2'd2, 8'hFF, 8'hFF}
  };

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic serve_call(input logic [15:0] exp, input string tag);
    chk(call_req === 1'b1, tag, call_req, 1);
    chk(call_addr === exp, tag, call_addr, exp);
    call_ack = 1; tick(); call_ack = 0;
    chk(busy === 1'b0 && call_req === 1'b0, "R11 idle after ack", busy, 0);
  endtask

  task automatic set_mode_enable(input logic [1:0] m);
    im_wr = 1; im_sel = m; ei_cmd = 1; tick();
    im_wr = 0; ei_cmd = 0;
    chk(iff1 && iff2 && im_mode === m, "R2 ei and mode write", {iff1, iff2, im_mode}, {2'b11, m});
  endtask

  task automatic run_entry(input logic [17:0] v);
    logic [1:0] m; logic [15:0] base, exp_tgt; int rd_n; bit fin;
    m = v[17:16]; base = v[15:0];
    set_mode_enable(m);
    i_page = v[15:8]; bus_data = v[7:0]; int_req = 1;
    tick();
    int_req = 0;
    exp_tgt = (m == 2) ? {mem(base + 16'd1), mem(base)} : 16'h0038;
    rd_n = 0; fin = 0;
    for (int k = 1; k <= 30 && !fin; k++) begin
      if (k == 1) chk(!iff1 && !iff2, "R3 enables cleared on accept", {iff1, iff2}, 0);
      if (k <= 6) begin
        logic [2:0] e;
        e = (k <= 3) ? 3'b011 : (k == 4) ? 3'b001 : (k == 5) ? 3'b110 : 3'b111;
        chk({m1_n, iorq_n, rfsh_n} === e, "R4 ack strobes", {m1_n, iorq_n, rfsh_n}, e);
        if (k == 5) bus_data = 8'hEE;
      end else begin
        vec_rd_ack = 0;
        if (op_inject) begin
          chk(m == 0 && k == 7, "R5 inject cycle", k, 7);
          chk(op_byte === v[7:0] && !call_req, "R5 inject byte", op_byte, v[7:0]);
          fin = 1;
        end else if (call_req) begin
          chk(k == ((m == 2) ? 10 : 7), (m == 2) ? "R7 call cycle" : "R6 call cycle", k, (m == 2) ? 10 : 7);
          serve_call(exp_tgt, (m == 2) ? "R7 table target" : "R6 restart target");
          fin = 1;
        end else if (vec_rd_req) begin
          logic [15:0] ea;
          ea = base + 16'(rd_n);
          if (rd_n == 0) chk(k == 8, "R7 first read cycle", k, 8);
          chk(vec_rd_addr === ea, "R7 read address", vec_rd_addr, ea);
          vec_rd_data = mem(vec_rd_addr); vec_rd_ack = 1; rd_n++;
        end
      end
      if (!fin) tick();
    end
    vec_rd_ack = 0;
    chk(fin == 1, "R5 R6 R7 entry completed", fin, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    chk(!iff1 && !iff2 && im_mode == 0, "R1 reset flags", {iff1, iff2, im_mode}, 0);
    chk(m1_n && iorq_n && rfsh_n && !call_req && !vec_rd_req && !op_inject && !busy,
        "R1 reset outputs", {m1_n, iorq_n, rfsh_n, busy}, 4'b1110);

    int_req = 1; repeat (4) tick();
    chk(m1_n && !busy, "R3 masked request ignored", {m1_n, busy}, 2'b10);
    int_req = 0;

    foreach (VECS[i]) run_entry(VECS[i]);

    // DI clears both
    ei_cmd = 1; tick(); ei_cmd = 0; di_cmd = 1; tick(); di_cmd = 0;
    chk(!iff1 && !iff2, "R2 di clears", {iff1, iff2}, 0);

    // NMI with enables set
    ei_cmd = 1; tick(); ei_cmd = 0;
    nmi_in = 1; tick();
    chk(halt_release && !m1_n, "R8 nmi fetch pulse", {halt_release, m1_n}, 2'b10);
    chk(!iff1 && iff2, "R8 nmi saves enable", {iff1, iff2}, 2'b01);
    tick();
    chk(m1_n && !halt_release, "R8 single m1 pulse", {m1_n, halt_release}, 2'b10);
    serve_call(16'h0066, "R8 nmi target");
    repeat (4) tick();
    chk(!busy && !call_req, "R8 held level no retrigger", busy, 0);
    nmi_in = 0;
    retn_cmd = 1; tick(); retn_cmd = 0;
    chk(iff1 && iff2, "R10 retn restores", {iff1, iff2}, 2'b11);

    // NMI with primary enable clear
    di_cmd = 1; tick(); di_cmd = 0;
    nmi_in = 1; tick(); nmi_in = 0;
    chk(!iff1 && !iff2, "R8 nmi saves cleared enable", {iff1, iff2}, 0);
    tick(); serve_call(16'h0066, "R8 nmi target again");
    retn_cmd = 1; tick(); retn_cmd = 0;
    chk(!iff1, "R10 retn restores zero", iff1, 0);

    // Priority: NMI and enabled INT together
    set_mode_enable(2'd1);
    nmi_in = 1; int_req = 1; tick();
    chk(halt_release && iorq_n, "R9 nmi wins", {halt_release, iorq_n}, 2'b11);
    int_req = 0;
    tick();
    chk(call_addr === 16'h0066, "R9 nmi target first", call_addr, 16'h0066);
    tick(); tick();
    chk(call_req && call_addr === 16'h0066, "R11 request held", {call_req, call_addr}, 17'h10066);
    serve_call(16'h0066, "R9 served");
    nmi_in = 0;

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule